// File: doc/BRIEF.md
# Double-Buffered Sprite Attribute Store

This block keeps the sprite attribute table for a raster video pipeline in two copies. The processor writes and reads a staging copy through a simple request/acknowledge bus. The sprite engine reads a separate active copy, one record per request. Each record is four bytes. Byte offset 0 holds the vertical position, offset 1 holds the code/attribute byte, offset 2 holds the horizontal position, and offset 3 is spare. Positions sit on a 2x2 pixel grid, so the engine port returns them already doubled into pixel coordinates.

Each frame, when the raster reaches the first line after the visible area, a transfer sequencer copies every staging byte into the active copy, one byte per `BYTE_PERIOD` clocks. A transfer window spans `XFER_LINES` scanlines. While the window is open, processor requests wait and engine reads are refused. When the window closes, a waiting processor access completes. Processor edits therefore reach the engine only at the next frame boundary, and never partway through a frame.

Top module: `sprite_shadow_ram`

## Requirements
- R1: While reset is held, `cpu_ack`, `cpu_wait`, `xfer_busy`, `xfer_done` and `eng_valid` are all low.
- R2: A processor request accepted outside the transfer window is acknowledged by a one-cycle `cpu_ack` on the following cycle. On a read, `cpu_rdata` during that ack cycle holds the staging byte last written at `cpu_addr`.
- R3: A processor request present while `vcnt` is within lines `XFER_LINE` to `XFER_LINE+XFER_LINES-1` raises `cpu_wait` and gets no ack. It is accepted on the first cycle the window is closed, which is line `XFER_LINE+XFER_LINES` at `hcnt` 0, and is acknowledged on the cycle after that.
- R4: A transfer starts when `vcnt` equals `XFER_LINE` and `hcnt` equals 0. `xfer_busy` is high from the next cycle.
- R5: The transfer reads one staging byte every `BYTE_PERIOD` cycles, starting in the first busy cycle, and writes it to the active copy one cycle later. `xfer_done` pulses once, in the same cycle `xfer_busy` falls. That cycle is `(4*RECORDS-1)*BYTE_PERIOD+2` cycles after the cycle `xfer_busy` first went high.
- R6: After a transfer, an engine read of record i (`eng_idx`=i, outside the window) gives `eng_valid` on the next cycle. The outputs are then: `eng_vpos_px` = 2 × staging byte 4i, `eng_code` = staging byte 4i+1, and `eng_hpos_px` = 2 × staging byte 4i+2.
- R7: Processor writes made after a transfer do not change engine read results until the next transfer completes.
- R8: An engine read requested during the transfer window is ignored. `eng_valid` stays low on the next cycle and the engine outputs keep their previous values.
- R9: Byte offset 3 of each record is kept in the staging copy and reads back to the processor, but it never affects any engine output.
- R10: Exactly one `xfer_done` pulse occurs per transfer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcnt | input | HW | Horizontal raster count |
| vcnt | input | VW | Vertical raster (line) count |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | log2(4*RECORDS) | Byte address in the staging copy |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_wait | output | 1 | Request is being held off by the transfer window |
| eng_rd | input | 1 | Engine record read request |
| eng_idx | input | log2(RECORDS) | Record index |
| eng_valid | output | 1 | Engine outputs updated this cycle |
| eng_vpos_px | output | 9 | Vertical position in pixels |
| eng_code | output | 8 | Code/attribute byte |
| eng_hpos_px | output | 9 | Horizontal position in pixels |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse when the last byte is written |

## Verification
The bench builds the block with 16 records (64 bytes), `BYTE_PERIOD` of 2, a transfer line of 16 and 8-bit raster counters. It drives a raster of 70 clocks per line and 20 lines per frame. With these values a frame lasts 1400 cycles, so many full frames fit in one run: staging fill, transfer, engine readback and re-edit each happen several times. Even so, a 128-cycle copy still sits inside a 140-cycle window, which exercises the divider and the exact completion cycle. The small table also lets every record be read back after each transfer, so both double-buffer visibility and the spare byte are checked record by record.

// File: rtl/sprite_shadow_pkg.sv
package sprite_shadow_pkg;

  localparam int unsigned POS_W     = 8;
  localparam int unsigned PX_W      = POS_W + 1;
  localparam int unsigned REC_BYTES = 4;

  typedef enum logic [1:0] {
    FLD_VPOS  = 2'd0,
    FLD_CODE  = 2'd1,
    FLD_HPOS  = 2'd2,
    FLD_SPARE = 2'd3
  } rec_field_e;

  // Positions live on a 2x2 grid: pixel coordinate is twice the stored value.
  function automatic logic [PX_W-1:0] grid_to_px(input logic [POS_W-1:0] pos);
    return {pos, 1'b0};
  endfunction

  function automatic rec_field_e field_of(input logic [15:0] byte_addr);
    return rec_field_e'(byte_addr[1:0]);
  endfunction

  function automatic logic [15:0] row_of(input logic [15:0] byte_addr);
    return byte_addr >> 2;
  endfunction

  function automatic logic line_in_window(input int unsigned line,
                                          input int unsigned first,
                                          input int unsigned count);
    return (line >= first) && (line < first + count);
  endfunction

endpackage

// File: rtl/spr_stage_ram.sv
module spr_stage_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/spr_lane_ram.sv
module spr_lane_ram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/spr_xfer_ctrl.sv
module spr_xfer_ctrl
  import sprite_shadow_pkg::*;
#(
  parameter int unsigned BYTES       = 512,
  parameter int unsigned AW          = 9,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 10,
  parameter int unsigned XFER_LINE   = 480,
  parameter int unsigned XFER_LINES  = 2,
  parameter int unsigned BYTE_PERIOD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  output logic          xfer_win,
  output logic          xfer_start,
  output logic          xfer_busy,
  output logic          xfer_rd,
  output logic [AW-1:0] rd_addr,
  output logic          xfer_wr,
  output logic [AW-1:0] wr_addr,
  output logic          xfer_done
);

  localparam int unsigned DIV_W   = (BYTE_PERIOD > 1) ? $clog2(BYTE_PERIOD) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BYTE_PERIOD - 1);
  localparam logic [AW-1:0] LAST_IDX    = AW'(BYTES - 1);

  logic [DIV_W-1:0] div_q;
  logic [AW-1:0]    rd_idx_q;
  logic             rd_done_q;
  logic             wr_pend_q;
  logic [AW-1:0]    wr_idx_q;
  logic             busy_q;
  logic             done_q;
  logic             last_wr;

  assign xfer_win   = line_in_window(int'(vcnt), XFER_LINE, XFER_LINES);
  assign xfer_start = (vcnt == VW'(XFER_LINE)) && (hcnt == '0);
  assign xfer_rd    = busy_q && (div_q == '0) && !rd_done_q;
  assign last_wr    = wr_pend_q && (wr_idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      div_q     <= '0;
      rd_idx_q  <= '0;
      rd_done_q <= 1'b0;
      wr_pend_q <= 1'b0;
      wr_idx_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      wr_pend_q <= xfer_rd;
      wr_idx_q  <= rd_idx_q;
      done_q    <= last_wr;
      if (xfer_start) begin
        busy_q    <= 1'b1;
        div_q     <= '0;
        rd_idx_q  <= '0;
        rd_done_q <= 1'b0;
      end else if (busy_q) begin
        div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        if (xfer_rd) begin
          rd_idx_q <= rd_idx_q + 1'b1;
          if (rd_idx_q == LAST_IDX) rd_done_q <= 1'b1;
        end
        if (last_wr) busy_q <= 1'b0;
      end
    end
  end

  assign xfer_busy = busy_q;
  assign rd_addr   = rd_idx_q;
  assign xfer_wr   = wr_pend_q;
  assign wr_addr   = wr_idx_q;
  assign xfer_done = done_q;

endmodule

// File: rtl/sprite_shadow_ram.sv
module sprite_shadow_ram
  import sprite_shadow_pkg::*;
#(
  parameter int unsigned RECORDS     = 128,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 10,
  parameter int unsigned XFER_LINE   = 480,
  parameter int unsigned XFER_LINES  = 2,
  parameter int unsigned BYTE_PERIOD = 2,
  localparam int unsigned BYTES      = RECORDS * REC_BYTES,
  localparam int unsigned AW         = $clog2(BYTES),
  localparam int unsigned RW         = $clog2(RECORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HW-1:0]    hcnt,
  input  logic [VW-1:0]    vcnt,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [POS_W-1:0] cpu_wdata,
  output logic [POS_W-1:0] cpu_rdata,
  output logic             cpu_ack,
  output logic             cpu_wait,
  input  logic             eng_rd,
  input  logic [RW-1:0]    eng_idx,
  output logic             eng_valid,
  output logic [PX_W-1:0]  eng_vpos_px,
  output logic [POS_W-1:0] eng_code,
  output logic [PX_W-1:0]  eng_hpos_px,
  output logic             xfer_busy,
  output logic             xfer_done
);

  localparam int unsigned ENG_LANES = 3;

  logic             xfer_win, xfer_start, xfer_rd, xfer_wr;
  logic [AW-1:0]    rd_addr, wr_addr;
  logic             cpu_accept, eng_accept;
  logic             ack_q, eng_valid_q;
  logic [AW-1:0]    stage_addr;
  logic             stage_we;
  logic [POS_W-1:0] stage_rdata;
  logic [POS_W-1:0] lane_q [ENG_LANES];

  spr_xfer_ctrl #(
    .BYTES(BYTES), .AW(AW), .HW(HW), .VW(VW),
    .XFER_LINE(XFER_LINE), .XFER_LINES(XFER_LINES), .BYTE_PERIOD(BYTE_PERIOD)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .xfer_win(xfer_win), .xfer_start(xfer_start), .xfer_busy(xfer_busy),
    .xfer_rd(xfer_rd), .rd_addr(rd_addr), .xfer_wr(xfer_wr),
    .wr_addr(wr_addr), .xfer_done(xfer_done)
  );

  // Processor side: one access every other cycle, blocked by the window.
  assign cpu_accept = cpu_req && !xfer_win && !xfer_busy && !ack_q;
  assign cpu_wait   = cpu_req && (xfer_win || xfer_busy);
  assign stage_addr = xfer_busy ? rd_addr : cpu_addr;
  assign stage_we   = cpu_accept && cpu_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= cpu_accept;
  end

  spr_stage_ram #(.DEPTH(BYTES), .AW(AW), .DW(POS_W)) u_stage (
    .clk(clk), .we(stage_we), .addr(stage_addr),
    .wdata(cpu_wdata), .rdata(stage_rdata)
  );

  assign cpu_rdata = stage_rdata;
  assign cpu_ack   = ack_q;

  // Engine side: active copy split into one lane per used record field.
  assign eng_accept = eng_rd && !xfer_win && !xfer_busy;

  for (genvar g = 0; g < ENG_LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = xfer_wr && (field_of(16'(wr_addr)) == rec_field_e'(g));
    spr_lane_ram #(.DEPTH(RECORDS), .AW(RW), .DW(POS_W)) u_lane (
      .clk(clk), .we(lane_we), .waddr(RW'(row_of(16'(wr_addr)))),
      .wdata(stage_rdata), .re(eng_accept), .raddr(eng_idx),
      .rdata(lane_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eng_valid_q <= 1'b0;
    else        eng_valid_q <= eng_accept;
  end

  assign eng_valid   = eng_valid_q;
  assign eng_vpos_px = grid_to_px(lane_q[FLD_VPOS]);
  assign eng_code    = lane_q[FLD_CODE];
  assign eng_hpos_px = grid_to_px(lane_q[FLD_HPOS]);

endmodule

// File: rtl/sprite_shadow_ram_chk.sv
module sprite_shadow_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_wait,
  input logic cpu_ack,
  input logic xfer_win,
  input logic xfer_start,
  input logic xfer_busy,
  input logic xfer_rd,
  input logic xfer_wr,
  input logic xfer_done,
  input logic eng_rd,
  input logic eng_valid
);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R3
  wait_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |=> !cpu_ack);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> xfer_busy);

  // R5
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_wr |-> $past(xfer_rd));

  // R5
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_busy) |-> xfer_done);

  // R8
  eng_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rd && xfer_win) |=> !eng_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

endmodule

bind sprite_shadow_ram sprite_shadow_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wait(cpu_wait), .cpu_ack(cpu_ack),
  .xfer_win(xfer_win), .xfer_start(xfer_start), .xfer_busy(xfer_busy),
  .xfer_rd(xfer_rd), .xfer_wr(xfer_wr), .xfer_done(xfer_done),
  .eng_rd(eng_rd), .eng_valid(eng_valid)
);

// File: tb/test_sprite_shadow_ram.sv
`timescale 1ns/1ps
module test_sprite_shadow_ram;

  localparam int RECORDS = 16;
  localparam int BYTES   = RECORDS * 4;
  localparam int AW      = $clog2(BYTES);
  localparam int RW      = $clog2(RECORDS);
  localparam int HW = 8, VW = 8;
  localparam int XLINE = 16, XLINES = 2, PERIOD = 2;
  localparam int H_TOTAL = 70, V_TOTAL = 20;
  localparam int EXP_GAP = (BYTES - 1) * PERIOD + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ack, cpu_wait;
  logic eng_rd = 0;
  logic [RW-1:0] eng_idx = '0;
  logic eng_valid;
  logic [8:0] eng_vpos_px, eng_hpos_px;
  logic [7:0] eng_code;
  logic xfer_busy, xfer_done;

  int checks = 0, errors = 0;
  logic [7:0] stage_m [BYTES];
  logic [7:0] act_m [BYTES];

  always #2.5 clk = ~clk;

  sprite_shadow_ram #(
    .RECORDS(RECORDS), .HW(HW), .VW(VW), .XFER_LINE(XLINE),
    .XFER_LINES(XLINES), .BYTE_PERIOD(PERIOD)
  ) i_sprite_shadow_ram (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .cpu_wait(cpu_wait), .eng_rd(eng_rd), .eng_idx(eng_idx),
    .eng_valid(eng_valid), .eng_vpos_px(eng_vpos_px), .eng_code(eng_code),
    .eng_hpos_px(eng_hpos_px), .xfer_busy(xfer_busy), .xfer_done(xfer_done)
  );

  // Raster generator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; vcnt <= '0;
    end else if (hcnt == HW'(H_TOTAL - 1)) begin
      hcnt <= '0;
      vcnt <= (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int px(input logic [7:0] b);
    return int'(b) * 2;
  endfunction

  task automatic wait_safe();
    do @(negedge clk); while (!(vcnt >= 1 && vcnt <= XLINE - 4));
  endtask

  task automatic cpu_access(input logic we, input int addr, input logic [7:0] wd,
                            output logic [7:0] rd);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = wd;
    do @(negedge clk); while (!cpu_ack);
    rd = cpu_rdata;
    cpu_req = 0; cpu_we = 0;
    if (we) stage_m[addr] = wd;
  endtask

  task automatic eng_read(input int idx, input string req);
    eng_rd = 1; eng_idx = RW'(idx);
    @(negedge clk);
    eng_rd = 0;
    chk({req, " eng_valid"}, int'(eng_valid), 1);
    chk({req, " vpos"}, int'(eng_vpos_px), px(act_m[4*idx]));
    chk({req, " code"}, int'(eng_code),    int'(act_m[4*idx+1]));
    chk({req, " hpos"}, int'(eng_hpos_px), px(act_m[4*idx+2]));
  endtask

  task automatic wait_transfer();
    do @(negedge clk); while (!xfer_done);
    for (int i = 0; i < BYTES; i++) act_m[i] = stage_m[i];
  endtask

  // Transfer timing monitor
  int starts = 0, dones = 0, gap = 0;
  logic busy_prev = 0;
  int prev_v = 0, prev_h = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (xfer_busy && !busy_prev) begin
        starts++;
        gap = 0;
        chk("R4 start line", prev_v, XLINE);
        chk("R4 start hcnt", prev_h, 0);
      end else if (busy_prev) begin
        gap++;
      end
      if (xfer_done) begin
        dones++;
        chk("R5 done cycle", gap, EXP_GAP);
        chk("R5 busy low at done", int'(xfer_busy), 0);
      end
      busy_prev = xfer_busy;
    end
    prev_v = int'(vcnt);
    prev_h = int'(hcnt);
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int a, pv, ph;
    logic [8:0] hold_v, hold_h;
    logic [7:0] hold_c;
    void'($urandom(32'd4711));
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cpu_ack", int'(cpu_ack), 0);
    chk("R1 cpu_wait", int'(cpu_wait), 0);
    chk("R1 xfer_busy", int'(xfer_busy), 0);
    chk("R1 xfer_done", int'(xfer_done), 0);
    chk("R1 eng_valid", int'(eng_valid), 0);
    rst_n = 1;

    // Fill staging with random data
    for (int i = 0; i < BYTES; i++) begin
      wait_safe();
      cpu_access(1, i, 8'($urandom), rd);
    end
    // R2 readback of random addresses, plus directed corners
    for (int k = 0; k < 10; k++) begin
      a = (k == 0) ? 0 : (k == 1) ? BYTES - 1 : int'($urandom % BYTES);
      wait_safe();
      cpu_access(0, a, 8'h00, rd);
      chk("R2 staging readback", int'(rd), int'(stage_m[a]));
    end

    wait_transfer();
    // R6 every record after the first transfer
    for (int r = 0; r < RECORDS; r++) begin
      wait_safe();
      eng_read(r, "R6");
    end

    // R7 and R9: edit records, engine still sees old copy
    for (int r = 0; r < RECORDS / 2; r++) begin
      for (int f = 0; f < 4; f++) begin
        wait_safe();
        cpu_access(1, 4*r + f, 8'($urandom), rd);
      end
    end
    wait_safe();
    cpu_access(1, 4*12 + 3, 8'hA5, rd);
    wait_safe();
    cpu_access(0, 4*12 + 3, 8'h00, rd);
    chk("R9 spare byte readback", int'(rd), 8'hA5);
    for (int r = 0; r < RECORDS; r++) begin
      wait_safe();
      eng_read(r, "R7 before next transfer");
    end

    // R3: request inside the window stalls until it closes
    do @(negedge clk); while (!(vcnt == XLINE && hcnt == 10));
    cpu_req = 1; cpu_we = 0; cpu_addr = AW'(4*3 + 1);
    @(negedge clk);
    chk("R3 cpu_wait in window", int'(cpu_wait), 1);
    pv = int'(vcnt); ph = int'(hcnt);
    while (!cpu_ack) begin
      pv = int'(vcnt); ph = int'(hcnt);
      @(negedge clk);
    end
    cpu_req = 0;
    chk("R3 accept line", pv, XLINE + XLINES);
    chk("R3 accept hcnt", ph, 0);
    chk("R3 stalled read data", int'(cpu_rdata), int'(stage_m[4*3 + 1]));
    for (int i = 0; i < BYTES; i++) act_m[i] = stage_m[i];

    // R7 new values visible, R9 spare edit did not disturb record 12
    for (int r = 0; r < RECORDS; r++) begin
      wait_safe();
      eng_read(r, "R7 after transfer");
    end

    // R8 engine read inside window is ignored
    wait_safe();
    eng_read(5, "R8 setup");
    hold_v = eng_vpos_px; hold_c = eng_code; hold_h = eng_hpos_px;
    do @(negedge clk); while (!(vcnt == XLINE + 1 && hcnt == 3));
    eng_rd = 1; eng_idx = RW'(9);
    @(negedge clk);
    eng_rd = 0;
    chk("R8 eng_valid", int'(eng_valid), 0);
    chk("R8 vpos held", int'(eng_vpos_px), int'(hold_v));
    chk("R8 code held", int'(eng_code), int'(hold_c));
    chk("R8 hpos held", int'(eng_hpos_px), int'(hold_h));

    // Random frames
    for (int fr = 0; fr < 4; fr++) begin
      for (int k = 0; k < 24; k++) begin
        a = int'($urandom % BYTES);
        wait_safe();
        cpu_access(1, a, 8'($urandom), rd);
      end
      wait_transfer();
      for (int k = 0; k < 8; k++) begin
        wait_safe();
        eng_read(int'($urandom % RECORDS), "R6 random");
      end
    end

    // R10 one done per start
    chk("R10 done count", dones, starts);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule